// File: doc/BRIEF.md
# Inter-CPU Command Mailbox

This block passes one 8-bit command at a time from a main processor to a sound processor. The main side writes a byte to its command address. The block keeps that byte and raises a pending flag. When the mode input selects interrupt delivery, the block also raises the sound processor's non-maskable interrupt line.

The sound side reads the byte at its own command address. It then writes to an acknowledge address, and that write drops both the flag and the interrupt. The data on that write does not matter. Either side can read the flag. Some sound software polls the flag and does not take the interrupt, so for those boards the mode input keeps the interrupt line low.

Each side has a plain bus with an address, a read strobe and a write strobe. Reads are combinational and return zero unless the strobe is high at a mapped address. Writes take effect at the clock edge that samples the strobe.

Top module: `cmd_mailbox`

## Requirements
- R1: A main-side write at address 0x20 stores `main_wdata` as the command byte and sets the pending flag, both visible from the next cycle.
- R2: While `nmi_en` is 1, a command write drives `snd_nmi` to 1 from the next cycle.
- R3: While `nmi_en` is 0, a command write still stores the byte and sets the flag, but `snd_nmi` stays 0.
- R4: A sound-side write at address 0x17 clears the pending flag and drives `snd_nmi` to 0 from the next cycle. A sound write at any other address does neither.
- R5: A main-side read at address 0x25 returns the pending flag on bit 0, with bits 7..1 at 0. A main-side read at any other address returns 0, and a main-side write at 0x25 has no effect.
- R6: A sound-side read at address 0x16 returns the latched command byte. When the flag port is enabled, a sound-side read at address 0x15 returns the pending flag on bit 0 with the upper bits at 0.
- R7: Reading the command byte or the flag, from either side, never changes the pending flag, the interrupt or the byte.
- R8: A command written while the flag is still 1 replaces the latched byte, and an interrupt that is already asserted stays asserted.
- R9: When a command write and an acknowledge hit the same edge, the write wins. The flag ends at 1, the byte is the new one, and `snd_nmi` follows `nmi_en`.
- R10: While `rst_n` is low, the byte is cleared to 0, the flag to 0 and `snd_nmi` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_en | input | 1 | 1 selects interrupt delivery, 0 selects polled mode |
| main_addr | input | 8 | Main-side port address |
| main_rd | input | 1 | Main-side read strobe |
| main_wr | input | 1 | Main-side write strobe |
| main_wdata | input | 8 | Main-side write data |
| main_rdata | output | 8 | Main-side read data |
| snd_addr | input | 8 | Sound-side port address |
| snd_rd | input | 1 | Sound-side read strobe |
| snd_wr | input | 1 | Sound-side write strobe |
| snd_rdata | output | 8 | Sound-side read data |
| snd_nmi | output | 1 | Non-maskable interrupt to the sound processor |

## Verification
Commands are sent in interrupt mode and in polled mode. A mistake that ties the interrupt to the flag shows up in one mode but not the other.

A second command sent before the acknowledge separates overwrite-and-hold from first-write-only latching. A write and an acknowledge on the same edge, tried in both modes, shows which one has priority and how the interrupt resolves.

Repeated reads taken while the flag is up show whether any read clears state. Writes and reads at the wrong addresses show whether the address decode is tight.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_DW = 8;

    typedef struct packed {
        logic [MBX_DW-1:0] cmd;
        logic              pend;
        logic              nmi;
    } mbx_state_t;
endpackage

// File: rtl/mbx_addr_match.sv
module mbx_addr_match #(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] MATCH  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel
);
    always_comb begin
        sel = (addr == MATCH);
    end
endmodule

// File: rtl/mbx_state.sv
module mbx_state
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_en,
    input  logic              cmd_wr,
    input  logic [MBX_DW-1:0] cmd_data,
    input  logic              ack_wr,
    output logic [MBX_DW-1:0] cmd_q,
    output logic              pend_q,
    output logic              nmi_q
);
    mbx_state_t st_d, st_q;

    // Acknowledge first, then command, so a command on the same edge wins.
    always_comb begin
        st_d = st_q;
        if (ack_wr) begin
            st_d.pend = 1'b0;
            st_d.nmi  = 1'b0;
        end
        if (cmd_wr) begin
            st_d.cmd  = cmd_data;
            st_d.pend = 1'b1;
            if (nmi_en) begin
                st_d.nmi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q  = st_q.cmd;
    assign pend_q = st_q.pend;
    assign nmi_q  = st_q.nmi;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] MAIN_CMD_ADR  = 8'h20,
    parameter logic [ADDR_W-1:0] MAIN_STAT_ADR = 8'h25,
    parameter logic [ADDR_W-1:0] SND_CMD_ADR   = 8'h16,
    parameter logic [ADDR_W-1:0] SND_ACK_ADR   = 8'h17,
    parameter logic [ADDR_W-1:0] SND_FLAG_ADR  = 8'h15,
    parameter bit                SND_FLAG_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_en,
    input  logic [ADDR_W-1:0] main_addr,
    input  logic              main_rd,
    input  logic              main_wr,
    input  logic [MBX_DW-1:0] main_wdata,
    output logic [MBX_DW-1:0] main_rdata,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic              snd_rd,
    input  logic              snd_wr,
    output logic [MBX_DW-1:0] snd_rdata,
    output logic              snd_nmi
);
    localparam int PAD_W = MBX_DW - 1;

    logic              m_cmd_sel, m_stat_sel, s_cmd_sel, s_ack_sel, s_flag_sel;
    logic [MBX_DW-1:0] cmd_q;
    logic              pend_q;
    logic              nmi_q;
    logic              cmd_wr, ack_wr;

    mbx_addr_match #(.ADDR_W(ADDR_W), .MATCH(MAIN_CMD_ADR)) u_m_cmd (
        .addr(main_addr), .sel(m_cmd_sel));
    mbx_addr_match #(.ADDR_W(ADDR_W), .MATCH(MAIN_STAT_ADR)) u_m_stat (
        .addr(main_addr), .sel(m_stat_sel));
    mbx_addr_match #(.ADDR_W(ADDR_W), .MATCH(SND_CMD_ADR)) u_s_cmd (
        .addr(snd_addr), .sel(s_cmd_sel));
    mbx_addr_match #(.ADDR_W(ADDR_W), .MATCH(SND_ACK_ADR)) u_s_ack (
        .addr(snd_addr), .sel(s_ack_sel));

    generate
        if (SND_FLAG_EN) begin : g_flag
            mbx_addr_match #(.ADDR_W(ADDR_W), .MATCH(SND_FLAG_ADR)) u_s_flag (
                .addr(snd_addr), .sel(s_flag_sel));
        end else begin : g_noflag
            assign s_flag_sel = 1'b0;
        end
    endgenerate

    assign cmd_wr = main_wr & m_cmd_sel;
    assign ack_wr = snd_wr & s_ack_sel;

    mbx_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_en  (nmi_en),
        .cmd_wr  (cmd_wr),
        .cmd_data(main_wdata),
        .ack_wr  (ack_wr),
        .cmd_q   (cmd_q),
        .pend_q  (pend_q),
        .nmi_q   (nmi_q)
    );

    always_comb begin
        main_rdata = '0;
        if (main_rd && m_stat_sel) begin
            main_rdata = {{PAD_W{1'b0}}, pend_q};
        end
    end

    always_comb begin
        snd_rdata = '0;
        if (snd_rd) begin
            if (s_cmd_sel) begin
                snd_rdata = cmd_q;
            end else if (s_flag_sel) begin
                snd_rdata = {{PAD_W{1'b0}}, pend_q};
            end
        end
    end

    assign snd_nmi = nmi_q;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] MAIN_CMD_ADR  = 8'h20,
    parameter logic [ADDR_W-1:0] SND_ACK_ADR   = 8'h17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi_en,
    input logic [ADDR_W-1:0] main_addr,
    input logic              main_wr,
    input logic [7:0]        main_wdata,
    input logic [7:0]        main_rdata,
    input logic [ADDR_W-1:0] snd_addr,
    input logic              snd_wr,
    input logic [7:0]        cmd_q,
    input logic              pend_q,
    input logic              snd_nmi
);
    logic wcmd, wack;
    assign wcmd = main_wr && (main_addr == MAIN_CMD_ADR);
    assign wack = snd_wr && (snd_addr == SND_ACK_ADR);

    assert_cmd_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wcmd |=> (pend_q && cmd_q == $past(main_wdata)));

    assert_nmi_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wcmd && nmi_en) |=> snd_nmi);

    assert_nmi_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snd_nmi) |-> $past(wcmd && nmi_en));

    assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wack && !wcmd) |=> (!pend_q && !snd_nmi));

    assert_stat_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        main_rdata[7:1] == 7'd0);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wcmd && !wack) |=> ($stable(pend_q) && $stable(cmd_q) && $stable(snd_nmi)));

    assert_nmi_implies_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snd_nmi |-> pend_q);

    assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wcmd && wack) |=> (pend_q && snd_nmi == $past(nmi_en)));
endmodule

bind cmd_mailbox mbx_checker #(
    .ADDR_W      (ADDR_W),
    .MAIN_CMD_ADR(MAIN_CMD_ADR),
    .SND_ACK_ADR (SND_ACK_ADR)
) u_mbx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_en    (nmi_en),
    .main_addr (main_addr),
    .main_wr   (main_wr),
    .main_wdata(main_wdata),
    .main_rdata(main_rdata),
    .snd_addr  (snd_addr),
    .snd_wr    (snd_wr),
    .cmd_q     (cmd_q),
    .pend_q    (pend_q),
    .snd_nmi   (snd_nmi)
);

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A_MCMD = 8'h20, A_MSTAT = 8'h25;
    localparam logic [7:0] A_SCMD = 8'h16, A_SACK = 8'h17, A_SFLAG = 8'h15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_en = 1'b1;
    logic [7:0] main_addr = '0, main_wdata = '0, snd_addr = '0;
    logic       main_rd = 1'b0, main_wr = 1'b0, snd_rd = 1'b0, snd_wr = 1'b0;
    logic [7:0] main_rdata, snd_rdata;
    logic       snd_nmi;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmd_mailbox dut (
        .clk(clk), .rst_n(rst_n), .nmi_en(nmi_en),
        .main_addr(main_addr), .main_rd(main_rd), .main_wr(main_wr),
        .main_wdata(main_wdata), .main_rdata(main_rdata),
        .snd_addr(snd_addr), .snd_rd(snd_rd), .snd_wr(snd_wr),
        .snd_rdata(snd_rdata), .snd_nmi(snd_nmi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic main_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        main_addr = a; main_wdata = d; main_wr = 1'b1;
        @(negedge clk);
        main_wr = 1'b0;
    endtask

    task automatic snd_write(input logic [7:0] a);
        @(negedge clk);
        snd_addr = a; snd_wr = 1'b1;
        @(negedge clk);
        snd_wr = 1'b0;
    endtask

    task automatic both_write(input logic [7:0] d);
        @(negedge clk);
        main_addr = A_MCMD; main_wdata = d; main_wr = 1'b1;
        snd_addr = A_SACK; snd_wr = 1'b1;
        @(negedge clk);
        main_wr = 1'b0; snd_wr = 1'b0;
    endtask

    task automatic main_read(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        main_addr = a; main_rd = 1'b1;
        #1 v = main_rdata;
        @(negedge clk);
        main_rd = 1'b0;
    endtask

    task automatic snd_read(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        snd_addr = a; snd_rd = 1'b1;
        #1 v = snd_rdata;
        @(negedge clk);
        snd_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 nmi in reset", {7'd0, snd_nmi}, 8'h00);
        rst_n = 1'b1;
        main_read(A_MSTAT, v); chk("R10 flag after reset", v, 8'h00);
        snd_read(A_SCMD, v);   chk("R10 byte after reset", v, 8'h00);
        chk("R10 nmi after reset", {7'd0, snd_nmi}, 8'h00);
    endtask

    task automatic t_nmi_mode;
        logic [7:0] v;
        nmi_en = 1'b1;
        main_write(A_MCMD, 8'hA5);
        chk("R2 nmi set", {7'd0, snd_nmi}, 8'h01);
        main_read(A_MSTAT, v); chk("R1/R5 main flag", v, 8'h01);
        snd_read(A_SCMD, v);   chk("R1/R6 byte", v, 8'hA5);
        snd_read(A_SFLAG, v);  chk("R6 sound flag", v, 8'h01);
        snd_write(A_SACK);
        chk("R4 nmi cleared", {7'd0, snd_nmi}, 8'h00);
        main_read(A_MSTAT, v); chk("R4 flag cleared", v, 8'h00);
    endtask

    task automatic t_polled;
        logic [7:0] v;
        nmi_en = 1'b0;
        main_write(A_MCMD, 8'h3C);
        chk("R3 nmi stays low", {7'd0, snd_nmi}, 8'h00);
        main_read(A_MSTAT, v); chk("R3 flag set", v, 8'h01);
        snd_read(A_SCMD, v);   chk("R3 byte", v, 8'h3C);
        snd_write(A_SACK);
        main_read(A_MSTAT, v); chk("R4 flag cleared polled", v, 8'h00);
    endtask

    task automatic t_read_no_clear;
        logic [7:0] v;
        nmi_en = 1'b1;
        main_write(A_MCMD, 8'h5A);
        snd_read(A_SCMD, v);
        snd_read(A_SCMD, v);
        snd_read(A_SFLAG, v);
        main_read(A_MSTAT, v); chk("R7 flag kept", v, 8'h01);
        chk("R7 nmi kept", {7'd0, snd_nmi}, 8'h01);
        snd_read(A_SCMD, v);   chk("R7 byte kept", v, 8'h5A);
        snd_write(A_SACK);
    endtask

    task automatic t_overwrite;
        logic [7:0] v;
        nmi_en = 1'b1;
        main_write(A_MCMD, 8'h11);
        nmi_en = 1'b0;
        main_write(A_MCMD, 8'h22);
        chk("R8 nmi held", {7'd0, snd_nmi}, 8'h01);
        snd_read(A_SCMD, v); chk("R8 byte replaced", v, 8'h22);
        snd_write(A_SACK);
        chk("R4 nmi cleared after overwrite", {7'd0, snd_nmi}, 8'h00);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        nmi_en = 1'b1;
        main_write(A_MCMD, 8'h77);
        both_write(8'h88);
        main_read(A_MSTAT, v); chk("R9 flag wins", v, 8'h01);
        snd_read(A_SCMD, v);   chk("R9 new byte", v, 8'h88);
        chk("R9 nmi in nmi mode", {7'd0, snd_nmi}, 8'h01);
        nmi_en = 1'b0;
        both_write(8'h99);
        main_read(A_MSTAT, v); chk("R9 flag wins polled", v, 8'h01);
        chk("R9 nmi in polled mode", {7'd0, snd_nmi}, 8'h00);
        snd_write(A_SACK);
    endtask

    task automatic t_decode;
        logic [7:0] v;
        nmi_en = 1'b1;
        main_write(A_MSTAT, 8'hFF);
        main_read(A_MSTAT, v); chk("R5 status write ignored", v, 8'h00);
        chk("R5 no nmi from status write", {7'd0, snd_nmi}, 8'h00);
        main_write(A_MCMD, 8'h42);
        main_read(A_MCMD, v);  chk("R5 unmapped main read", v, 8'h00);
        snd_write(A_SCMD);
        main_read(A_MSTAT, v); chk("R4 wrong ack address", v, 8'h01);
        snd_write(A_SACK);
    endtask

    initial begin
        t_reset();
        t_nmi_mode();
        t_polled();
        t_read_no_clear();
        t_overwrite();
        t_collision();
        t_decode();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule